// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

Two agents that share a resource coordinate through eight one-bit ownership flags. A flag belongs to the left port, to the right port, or to neither. A port claims a flag by writing a 0 to it. It gets the flag if the flag is free or already its own. If the other port holds the flag, the claim is remembered. The owner gives the flag up by writing a 1. If a claim is waiting at that moment, the flag passes straight to the waiting port.

Each port reads its own view of a flag. The port that owns the flag reads 0, and every other case reads 1. The value is copied onto all eight data lines, so software can test any bit. The unit is a synchronous model: every access takes one clock cycle, and a read result is registered.

Top module: `sema_flags`

## Requirements
- R1: After reset all eight flags are free and both data outputs read 8'hFF.
- R2: A port acts on the flags only while its select is 1 and its RAM enable is 0. With wr=1 it writes data bit `din`, and with wr=0 it reads. Any access while the select is 0 or the RAM enable is 1 changes no flag.
- R3: Writing 0 to a flag that is free or already owned by the writer grants it to the writer. Writing 0 to a flag held by the other port leaves the holder unchanged and records a waiting claim.
- R4: A read returns 0 on all eight bits (8'h00) when the reading port owns the flag, and 1 on all eight bits (8'hFF) otherwise.
- R5: A read issued in cycle N shows on the output after the clock edge that ends cycle N, and reflects every write from cycles before N. The output holds its value in cycles with no read.
- R6: Writing 1 frees a flag only when the writer owns it. When the writer does not own the flag, a 1 has no effect.
- R7: When the owner frees a flag that the other port is waiting for, the waiting port owns it on the next cycle.
- R8: When both ports write 0 to the same free flag in the same cycle, the left port wins and the right port's claim waits.
- R9: No flag is ever owned by both ports at once.
- R10: The 3-bit address picks one of eight independent flags, and the left and right ports behave as mirror images.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore select |
| l_ram_en | input | 1 | Left RAM enable; a flag access needs it at 0 |
| l_wr | input | 1 | Left write (1) or read (0) |
| l_addr | input | 3 | Left flag index |
| l_din | input | 1 | Left write data bit |
| l_dout | output | 8 | Left read data, flag view replicated |
| r_sel | input | 1 | Right semaphore select |
| r_ram_en | input | 1 | Right RAM enable; a flag access needs it at 0 |
| r_wr | input | 1 | Right write (1) or read (0) |
| r_addr | input | 3 | Right flag index |
| r_din | input | 1 | Right write data bit |
| r_dout | output | 8 | Right read data, flag view replicated |

## Verification
The bench drives each port alone first, claiming and freeing flags. This separates a grant from a waiting claim, and a real release from a 1 written by a port that does not own the flag. It then issues same-cycle claims on one flag and on two different flags. These tell the left-wins tie rule apart from plain independence between flag indices. A release in the same cycle as a read by the waiting port shows the one-cycle read latency and the handoff. Writes gated off by select or RAM enable are checked by reading the flag afterwards.

// File: rtl/sema_flags.sv
module sema_flags #(
  parameter int NF = 8,
  parameter int AW = $clog2(NF),
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_ram_en,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic          l_din,
  output logic [DW-1:0] l_dout,
  input  logic          r_sel,
  input  logic          r_ram_en,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic          r_din,
  output logic [DW-1:0] r_dout
);

  logic [NF-1:0] own_l, own_r, pend_l, pend_r;
  logic [NF-1:0] own_l_n, own_r_n, pend_l_n, pend_r_n;

  wire l_act = l_sel & ~l_ram_en;
  wire r_act = r_sel & ~r_ram_en;
  wire l_req = l_act & l_wr & ~l_din;
  wire r_req = r_act & r_wr & ~r_din;
  wire l_rel = l_act & l_wr & l_din;
  wire r_rel = r_act & r_wr & r_din;
  wire l_rd  = l_act & ~l_wr;
  wire r_rd  = r_act & ~r_wr;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    wire hit_l  = (l_addr == AW'(i));
    wire hit_r  = (r_addr == AW'(i));
    wire keep_l = own_l[i] & ~(l_rel & hit_l);
    wire keep_r = own_r[i] & ~(r_rel & hit_r);
    wire want_l = pend_l[i] | (l_req & hit_l);
    wire want_r = pend_r[i] | (r_req & hit_r);
    assign own_l_n[i]  = keep_l | (~keep_r & want_l);
    assign own_r_n[i]  = keep_r | (~keep_l & ~want_l & want_r);
    assign pend_l_n[i] = want_l & ~own_l_n[i];
    assign pend_r_n[i] = want_r & ~own_r_n[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_l  <= '0;
      own_r  <= '0;
      pend_l <= '0;
      pend_r <= '0;
      l_dout <= '1;
      r_dout <= '1;
    end else begin
      own_l  <= own_l_n;
      own_r  <= own_r_n;
      pend_l <= pend_l_n;
      pend_r <= pend_r_n;
      if (l_rd) l_dout <= {DW{~own_l[l_addr]}};
      if (r_rd) r_dout <= {DW{~own_r[r_addr]}};
    end
  end

endmodule

// File: rtl/sema_flags_chk.sv
module sema_flags_chk #(
  parameter int NF = 8,
  parameter int AW = $clog2(NF),
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_sel,
  input logic          l_ram_en,
  input logic          l_wr,
  input logic [AW-1:0] l_addr,
  input logic          l_din,
  input logic [DW-1:0] l_dout,
  input logic          r_sel,
  input logic          r_ram_en,
  input logic          r_wr,
  input logic [AW-1:0] r_addr,
  input logic          r_din,
  input logic [DW-1:0] r_dout,
  input logic [NF-1:0] own_l,
  input logic [NF-1:0] own_r
);

  wire lq = l_sel & ~l_ram_en & l_wr & ~l_din;
  wire rq = r_sel & ~r_ram_en & r_wr & ~r_din;
  wire r_wact = r_sel & ~r_ram_en & r_wr;
  wire l_wact = l_sel & ~l_ram_en & l_wr;

  AST_MUTEX: assert property (@(posedge clk) disable iff (!rst_n) (own_l & own_r) == '0); // R9
  AST_BYTE_L: assert property (@(posedge clk) disable iff (!rst_n) (l_dout == '0) || (l_dout == '1)); // R4
  AST_BYTE_R: assert property (@(posedge clk) disable iff (!rst_n) (r_dout == '0) || (r_dout == '1)); // R4
  AST_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_sel && !l_ram_en && !l_wr) |=> $stable(l_dout)); // R5
  AST_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_sel && !r_ram_en && !r_wr) |=> $stable(r_dout)); // R5
  AST_GRANT_L: assert property (@(posedge clk) disable iff (!rst_n)
    (lq && !own_r[l_addr]) |=> own_l[$past(l_addr)]); // R3
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (lq && rq && l_addr == r_addr && !own_l[l_addr] && !own_r[l_addr]) |=> !own_r[$past(r_addr)]); // R8
  AST_GATED_L: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_sel && !l_ram_en) && !r_wact) |=> ($stable(own_l) && $stable(own_r))); // R2
  AST_GATED_R: assert property (@(posedge clk) disable iff (!rst_n)
    (!(r_sel && !r_ram_en) && !l_wact) |=> ($stable(own_l) && $stable(own_r))); // R2

endmodule

bind sema_flags sema_flags_chk #(.NF(NF), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_ram_en(l_ram_en), .l_wr(l_wr), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
  .r_sel(r_sel), .r_ram_en(r_ram_en), .r_wr(r_wr), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout),
  .own_l(own_l), .own_r(own_r)
);

// File: tb/sema_flags_tb_top.sv
module sema_flags_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic l_sel = 0, l_ram_en = 0, l_wr = 0, l_din = 0;
  logic r_sel = 0, r_ram_en = 0, r_wr = 0, r_din = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [7:0] l_dout, r_dout;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sema_flags dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_ram_en(l_ram_en), .l_wr(l_wr), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
    .r_sel(r_sel), .r_ram_en(r_ram_en), .r_wr(r_wr), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_wr = 0; l_ram_en = 0;
    r_sel = 0; r_wr = 0; r_ram_en = 0;
  endtask

  task automatic lw(input int a, input bit d);
    l_sel = 1; l_ram_en = 0; l_wr = 1; l_addr = 3'(a); l_din = d;
    @(negedge clk); idle();
  endtask

  task automatic rw(input int a, input bit d);
    r_sel = 1; r_ram_en = 0; r_wr = 1; r_addr = 3'(a); r_din = d;
    @(negedge clk); idle();
  endtask

  task automatic both_w(input int la, input bit ld, input int ra, input bit rd);
    l_sel = 1; l_wr = 1; l_addr = 3'(la); l_din = ld;
    r_sel = 1; r_wr = 1; r_addr = 3'(ra); r_din = rd;
    @(negedge clk); idle();
  endtask

  task automatic rd(input int a, input logic [7:0] el, input logic [7:0] er, input string tag);
    l_sel = 1; l_wr = 0; l_addr = 3'(a);
    r_sel = 1; r_wr = 0; r_addr = 3'(a);
    @(negedge clk); idle();
    chk({tag, " left"}, l_dout, el);
    chk({tag, " right"}, r_dout, er);
    chk("R9 both own", 8'((l_dout == 8'h00) && (r_dout == 8'h00)), 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 left idle", l_dout, 8'hFF);
    chk("R1 right idle", r_dout, 8'hFF);
    for (int a = 0; a < 8; a++) rd(a, 8'hFF, 8'hFF, "R1 free");
  endtask

  task automatic t_claim_release();
    lw(3, 0);
    rd(3, 8'h00, 8'hFF, "R3 R4 left grant");
    rd(2, 8'hFF, 8'hFF, "R10 neighbour");
    rw(3, 0);
    rd(3, 8'h00, 8'hFF, "R3 right waits");
    lw(3, 1);
    rd(3, 8'hFF, 8'h00, "R7 handoff");
    rw(3, 1);
    rd(3, 8'hFF, 8'hFF, "R6 release");
  endtask

  task automatic t_nonowner();
    rw(6, 0);
    lw(6, 1);
    rd(6, 8'hFF, 8'h00, "R6 non-owner one");
    rw(6, 1);
    rd(6, 8'hFF, 8'hFF, "R6 no claim left");
  endtask

  task automatic t_gating();
    l_sel = 1; l_ram_en = 1; l_wr = 1; l_addr = 1; l_din = 0;
    @(negedge clk); idle();
    rd(1, 8'hFF, 8'hFF, "R2 ram enable");
    l_sel = 0; l_wr = 1; l_addr = 1; l_din = 0;
    @(negedge clk); idle();
    rd(1, 8'hFF, 8'hFF, "R2 no select");
    r_sel = 1; r_ram_en = 1; r_wr = 1; r_addr = 1; r_din = 0;
    @(negedge clk); idle();
    rd(1, 8'hFF, 8'hFF, "R2 right ram enable");
    lw(1, 0);
    r_sel = 1; r_ram_en = 1; r_wr = 0; r_addr = 1;
    @(negedge clk); idle();
    chk("R2 gated read holds", r_dout, 8'hFF);
    lw(1, 1);
  endtask

  task automatic t_tie();
    both_w(5, 0, 5, 0);
    rd(5, 8'h00, 8'hFF, "R8 left wins");
    lw(5, 1);
    rd(5, 8'hFF, 8'h00, "R8 right waited");
    rw(5, 1);
    both_w(0, 0, 7, 0);
    rd(0, 8'h00, 8'hFF, "R10 left flag0");
    rd(7, 8'hFF, 8'h00, "R10 right flag7");
    both_w(0, 1, 7, 1);
    rd(0, 8'hFF, 8'hFF, "R10 flag0 freed");
    rd(7, 8'hFF, 8'hFF, "R10 flag7 freed");
  endtask

  task automatic t_latency();
    lw(2, 0);
    l_sel = 1; l_wr = 0; l_addr = 2;
    @(negedge clk); idle();
    chk("R5 next-cycle read", l_dout, 8'h00);
    lw(2, 1);
    chk("R5 hold no read", l_dout, 8'h00);
    rd(2, 8'hFF, 8'hFF, "R5 after release");
    lw(4, 0);
    rw(4, 0);
    l_sel = 1; l_wr = 1; l_addr = 4; l_din = 1;
    r_sel = 1; r_wr = 0; r_addr = 4;
    @(negedge clk); idle();
    chk("R5 same-cycle read old", r_dout, 8'hFF);
    rd(4, 8'hFF, 8'h00, "R5 R7 new owner");
    rw(4, 1);
  endtask

  task automatic t_reclaim();
    lw(1, 0);
    lw(1, 0);
    rd(1, 8'h00, 8'hFF, "R3 reclaim own");
    rw(1, 1);
    rd(1, 8'h00, 8'hFF, "R6 right one ignored");
    lw(1, 1);
    rd(1, 8'hFF, 8'hFF, "R6 left frees");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_claim_release();
    t_nonowner();
    t_gating();
    t_tie();
    t_latency();
    t_reclaim();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule